// File: doc/BRIEF.md
# Expansion Card Select Controller

This block sits between a host and a row of expansion card slots on a shared peripheral bus. Each slot owns a block of 256 addresses in a bit-addressed I/O space. The host turns a card on by writing 1 to offset 0 of that card's block, and turns it off by writing 0 there. The block decodes every I/O bit access into a slot number and an offset, and passes the strobe to that slot only. It also remembers which single card is active, so that accesses to the common memory window at 0x4000–0x5FFF reach that card alone.

The slot count and the base address depend on the mode. In standard mode there are 16 slots, starting at 0x1000. In extended mode there are 28 slots, starting at 0x0400.

A recovery option deals with hosts that wrongly enable two cards at once. The block keeps one enable bit per slot. When the active card is switched off while other cards are still enabled, the block falls back to the highest-numbered card that is still enabled, and it reports this with a one-cycle error pulse.

Top module: `card_select_ctrl`

## Requirements
- R1: After reset no slot is active: `sel_o` is 0, `act_vld_o` is 0, `recover_err_o` is 0, and the per-slot enable record is empty.
- R2: In standard mode (`ext_mode_i`=0), an I/O address A with 0x1000 ≤ A ≤ 0x1FFF decodes to slot (A−0x1000)>>8 and offset A[7:0]. Addresses outside that range reach no slot.
- R3: In extended mode (`ext_mode_i`=1), an I/O address A with 0x0400 ≤ A ≤ 0x1FFF decodes to slot (A−0x0400)>>8, giving slots 0 to 27. Address 0x03FF reaches no slot. Enable writes work for all 28 slots.
- R4: An I/O write of 1 at offset 0 of a decoded slot makes that slot the active one on the next clock edge. From then on `sel_o` has only that bit set, `act_idx_o` holds the slot number and `act_vld_o` is 1. Any slot that was active before is replaced.
- R5: An I/O write of 0 at offset 0 of a slot that is not active leaves the active slot unchanged.
- R6: With `recover_en_i`=0, an I/O write of 0 at offset 0 of the active slot clears the selection on the next edge: `sel_o`=0 and `act_vld_o`=0.
- R7: With `recover_en_i`=1, disabling the active slot while other slots are still enabled selects the highest-numbered of those slots on the next edge, and `recover_err_o` is 1 for that one cycle. If no enabled slot remains, the selection clears and no error is raised.
- R8: While no slot is active, memory window reads return 0 and no `mem_rd_o` or `mem_wr_o` strobe is driven.
- R9: While a slot is active, a memory access in 0x4000–0x5FFF strobes only that slot's bit. `mem_off_o` carries the address minus 0x4000, and a read returns that slot's byte. An access outside the window strobes no slot and reads 0.
- R10: I/O bit reads and writes reach the decoded slot whether or not it is active. `io_rdata_o` returns that slot's bit, and `io_off_o` carries the offset.
- R11: I/O writes at a nonzero offset, and I/O writes that decode to no slot, leave the selection unchanged.
- R12: A memory access in the same cycle as an enable write is routed by the selection that held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_mode_i | input | 1 | 1 selects extended slot map (28 slots from 0x0400) |
| recover_en_i | input | 1 | 1 enables fallback to another enabled slot |
| io_rd_i | input | 1 | I/O bit read strobe from host |
| io_wr_i | input | 1 | I/O bit write strobe from host |
| io_addr_i | input | 16 | I/O bit address |
| io_wdata_i | input | 1 | I/O bit write value |
| io_rdata_o | output | 1 | I/O bit read value returned to host |
| io_rd_o | output | 28 | Per-slot I/O read strobe |
| io_wr_o | output | 28 | Per-slot I/O write strobe |
| io_off_o | output | 8 | Offset within the decoded slot |
| io_wdata_o | output | 1 | I/O bit write value to cards |
| io_rdata_i | input | 28 | Per-slot I/O read bit |
| mem_rd_i | input | 1 | Memory read strobe from host |
| mem_wr_i | input | 1 | Memory write strobe from host |
| mem_addr_i | input | 16 | Memory byte address |
| mem_wdata_i | input | 8 | Memory write byte |
| mem_rdata_o | output | 8 | Memory read byte returned to host |
| mem_rd_o | output | 28 | Per-slot memory read strobe |
| mem_wr_o | output | 28 | Per-slot memory write strobe |
| mem_off_o | output | 13 | Offset within memory window |
| mem_wdata_o | output | 8 | Memory write byte to cards |
| mem_rdata_i | input | 224 | Per-slot read bytes, slot k at bits [8k+7:8k] |
| sel_o | output | 28 | One-hot active slot select |
| act_idx_o | output | 5 | Active slot number |
| act_vld_o | output | 1 | An active slot exists |
| recover_err_o | output | 1 | One-cycle pulse when recovery picked a fallback slot |

## Verification
Card switching and memory routing can happen in the same cycle: the host writes an enable bit while it also reads or writes the memory window. The bench sets this up by driving both strobes in one cycle. It checks that the memory strobe and the read byte in that cycle come from the slot that was active before the write. After the clock edge, a second window access must go to the newly enabled slot.

// File: rtl/card_sel_pkg.sv
package card_sel_pkg;
  localparam int unsigned ADDR_W    = 16;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned NSLOT_STD = 16;
  localparam int unsigned NSLOT_EXT = 28;
  localparam int unsigned SPAN_LG   = 8;
  localparam logic [15:0] STD_BASE  = 16'h1000;
  localparam logic [15:0] EXT_BASE  = 16'h0400;
  localparam logic [15:0] WIN_LO    = 16'h4000;
  localparam logic [15:0] WIN_HI    = 16'h5FFF;
endpackage

// File: rtl/csel_slot_decode.sv
module csel_slot_decode #(
  parameter int unsigned ADDR_W    = card_sel_pkg::ADDR_W,
  parameter int unsigned SPAN_LG   = card_sel_pkg::SPAN_LG,
  parameter int unsigned NSLOT_STD = card_sel_pkg::NSLOT_STD,
  parameter int unsigned NSLOT_EXT = card_sel_pkg::NSLOT_EXT,
  parameter logic [ADDR_W-1:0] STD_BASE = card_sel_pkg::STD_BASE,
  parameter logic [ADDR_W-1:0] EXT_BASE = card_sel_pkg::EXT_BASE,
  localparam int unsigned IDX_W = $clog2(NSLOT_EXT),
  localparam int unsigned SW    = ADDR_W - SPAN_LG
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               ext_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [SPAN_LG-1:0] off_o
);
  logic [ADDR_W-1:0] base, diff;
  logic [SW-1:0]     slot_full, lim;

  always_comb begin
    base      = ext_i ? EXT_BASE : STD_BASE;
    lim       = ext_i ? SW'(NSLOT_EXT) : SW'(NSLOT_STD);
    diff      = addr_i - base;
    slot_full = diff[ADDR_W-1:SPAN_LG];
    hit_o     = (addr_i >= base) && (slot_full < lim);
    idx_o     = slot_full[IDX_W-1:0];
    off_o     = diff[SPAN_LG-1:0];
  end
endmodule

// File: rtl/csel_io_route.sv
module csel_io_route #(
  parameter int unsigned NSLOT   = card_sel_pkg::NSLOT_EXT,
  parameter int unsigned SPAN_LG = card_sel_pkg::SPAN_LG,
  localparam int unsigned IDX_W  = $clog2(NSLOT)
) (
  input  logic               hit_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [SPAN_LG-1:0] off_i,
  input  logic               io_rd_i,
  input  logic               io_wr_i,
  input  logic               io_wdata_i,
  input  logic [NSLOT-1:0]   io_rdata_i,
  output logic [NSLOT-1:0]   io_rd_o,
  output logic [NSLOT-1:0]   io_wr_o,
  output logic [SPAN_LG-1:0] io_off_o,
  output logic               io_wdata_o,
  output logic               io_rdata_o
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic here;
    assign here       = hit_i && (idx_i == IDX_W'(g));
    assign io_rd_o[g] = io_rd_i && here;
    assign io_wr_o[g] = io_wr_i && here;
  end

  assign io_off_o   = off_i;
  assign io_wdata_o = io_wdata_i;
  // reads pass through regardless of which card is active
  assign io_rdata_o = io_rd_i && hit_i && io_rdata_i[idx_i];
endmodule

// File: rtl/csel_select_state.sv
module csel_select_state #(
  parameter int unsigned NSLOT  = card_sel_pkg::NSLOT_EXT,
  localparam int unsigned IDX_W = $clog2(NSLOT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             recover_en_i,
  input  logic             en_wr_i,
  input  logic             en_val_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [NSLOT-1:0] sel_o,
  output logic [IDX_W-1:0] act_idx_o,
  output logic             act_vld_o,
  output logic             err_o
);
  logic [NSLOT-1:0] mask_q, mask_d, sel_d, slot_bit;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             vld_q, vld_d, err_d;

  function automatic logic [IDX_W-1:0] top_slot(input logic [NSLOT-1:0] m);
    top_slot = '0;
    for (int i = 0; i < NSLOT; i++) if (m[i]) top_slot = IDX_W'(i);
  endfunction

  always_comb begin
    slot_bit = NSLOT'(1) << idx_i;
    mask_d   = mask_q;
    idx_d    = idx_q;
    vld_d    = vld_q;
    err_d    = 1'b0;
    if (en_wr_i) begin
      if (en_val_i) begin
        mask_d = mask_q | slot_bit;
        idx_d  = idx_i;
        vld_d  = 1'b1;
      end else begin
        mask_d = mask_q & ~slot_bit;
        // only the active slot's own disable drops the selection
        if (vld_q && (idx_q == idx_i)) begin
          if (recover_en_i && (|mask_d)) begin
            idx_d = top_slot(mask_d);
            err_d = 1'b1;
          end else begin
            idx_d = '0;
            vld_d = 1'b0;
          end
        end
      end
    end
    sel_d = vld_d ? (NSLOT'(1) << idx_d) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      idx_q  <= '0;
      vld_q  <= 1'b0;
      sel_o  <= '0;
      err_o  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      idx_q  <= idx_d;
      vld_q  <= vld_d;
      sel_o  <= sel_d;
      err_o  <= err_d;
    end
  end

  assign act_idx_o = idx_q;
  assign act_vld_o = vld_q;
endmodule

// File: rtl/csel_mem_route.sv
module csel_mem_route #(
  parameter int unsigned NSLOT  = card_sel_pkg::NSLOT_EXT,
  parameter int unsigned ADDR_W = card_sel_pkg::ADDR_W,
  parameter int unsigned DATA_W = card_sel_pkg::DATA_W,
  parameter logic [ADDR_W-1:0] WIN_LO = card_sel_pkg::WIN_LO,
  parameter logic [ADDR_W-1:0] WIN_HI = card_sel_pkg::WIN_HI,
  localparam int unsigned IDX_W  = $clog2(NSLOT),
  localparam int unsigned WIN_AW = $clog2(int'(WIN_HI) - int'(WIN_LO) + 1)
) (
  input  logic [NSLOT-1:0]        sel_i,
  input  logic [IDX_W-1:0]        act_idx_i,
  input  logic                    act_vld_i,
  input  logic                    mem_rd_i,
  input  logic                    mem_wr_i,
  input  logic [ADDR_W-1:0]       mem_addr_i,
  input  logic [DATA_W-1:0]       mem_wdata_i,
  input  logic [NSLOT*DATA_W-1:0] mem_rdata_i,
  output logic [NSLOT-1:0]        mem_rd_o,
  output logic [NSLOT-1:0]        mem_wr_o,
  output logic [WIN_AW-1:0]       mem_off_o,
  output logic [DATA_W-1:0]       mem_wdata_o,
  output logic [DATA_W-1:0]       mem_rdata_o
);
  logic [DATA_W-1:0] card_rd [NSLOT];
  logic [ADDR_W-1:0] rel;
  logic              win;

  for (genvar g = 0; g < NSLOT; g++) begin : g_card
    assign card_rd[g] = mem_rdata_i[g*DATA_W +: DATA_W];
  end

  assign win         = (mem_addr_i >= WIN_LO) && (mem_addr_i <= WIN_HI);
  assign rel         = mem_addr_i - WIN_LO;
  assign mem_off_o   = rel[WIN_AW-1:0];
  assign mem_wdata_o = mem_wdata_i;
  assign mem_rd_o    = (mem_rd_i && win && act_vld_i) ? sel_i : '0;
  assign mem_wr_o    = (mem_wr_i && win && act_vld_i) ? sel_i : '0;
  assign mem_rdata_o = (mem_rd_i && win && act_vld_i) ? card_rd[act_idx_i] : '0;
endmodule

// File: rtl/card_select_ctrl.sv
module card_select_ctrl #(
  parameter int unsigned ADDR_W    = card_sel_pkg::ADDR_W,
  parameter int unsigned DATA_W    = card_sel_pkg::DATA_W,
  parameter int unsigned NSLOT_STD = card_sel_pkg::NSLOT_STD,
  parameter int unsigned NSLOT_EXT = card_sel_pkg::NSLOT_EXT,
  parameter int unsigned SPAN_LG   = card_sel_pkg::SPAN_LG,
  parameter logic [ADDR_W-1:0] STD_BASE = card_sel_pkg::STD_BASE,
  parameter logic [ADDR_W-1:0] EXT_BASE = card_sel_pkg::EXT_BASE,
  parameter logic [ADDR_W-1:0] WIN_LO   = card_sel_pkg::WIN_LO,
  parameter logic [ADDR_W-1:0] WIN_HI   = card_sel_pkg::WIN_HI,
  localparam int unsigned NSLOT  = NSLOT_EXT,
  localparam int unsigned IDX_W  = $clog2(NSLOT),
  localparam int unsigned WIN_AW = $clog2(int'(WIN_HI) - int'(WIN_LO) + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ext_mode_i,
  input  logic                    recover_en_i,
  input  logic                    io_rd_i,
  input  logic                    io_wr_i,
  input  logic [ADDR_W-1:0]       io_addr_i,
  input  logic                    io_wdata_i,
  output logic                    io_rdata_o,
  output logic [NSLOT-1:0]        io_rd_o,
  output logic [NSLOT-1:0]        io_wr_o,
  output logic [SPAN_LG-1:0]      io_off_o,
  output logic                    io_wdata_o,
  input  logic [NSLOT-1:0]        io_rdata_i,
  input  logic                    mem_rd_i,
  input  logic                    mem_wr_i,
  input  logic [ADDR_W-1:0]       mem_addr_i,
  input  logic [DATA_W-1:0]       mem_wdata_i,
  output logic [DATA_W-1:0]       mem_rdata_o,
  output logic [NSLOT-1:0]        mem_rd_o,
  output logic [NSLOT-1:0]        mem_wr_o,
  output logic [WIN_AW-1:0]       mem_off_o,
  output logic [DATA_W-1:0]       mem_wdata_o,
  input  logic [NSLOT*DATA_W-1:0] mem_rdata_i,
  output logic [NSLOT-1:0]        sel_o,
  output logic [IDX_W-1:0]        act_idx_o,
  output logic                    act_vld_o,
  output logic                    recover_err_o
);
  logic               dec_hit;
  logic [IDX_W-1:0]   dec_idx;
  logic [SPAN_LG-1:0] dec_off;
  logic               en_wr;

  csel_slot_decode #(
    .ADDR_W(ADDR_W), .SPAN_LG(SPAN_LG), .NSLOT_STD(NSLOT_STD),
    .NSLOT_EXT(NSLOT_EXT), .STD_BASE(STD_BASE), .EXT_BASE(EXT_BASE)
  ) i_decode (
    .addr_i(io_addr_i), .ext_i(ext_mode_i),
    .hit_o(dec_hit), .idx_o(dec_idx), .off_o(dec_off)
  );

  csel_io_route #(.NSLOT(NSLOT), .SPAN_LG(SPAN_LG)) i_io (
    .hit_i(dec_hit), .idx_i(dec_idx), .off_i(dec_off),
    .io_rd_i(io_rd_i), .io_wr_i(io_wr_i), .io_wdata_i(io_wdata_i),
    .io_rdata_i(io_rdata_i), .io_rd_o(io_rd_o), .io_wr_o(io_wr_o),
    .io_off_o(io_off_o), .io_wdata_o(io_wdata_o), .io_rdata_o(io_rdata_o)
  );

  assign en_wr = io_wr_i && dec_hit && (dec_off == '0);

  csel_select_state #(.NSLOT(NSLOT)) i_state (
    .clk_i(clk_i), .rst_ni(rst_ni), .recover_en_i(recover_en_i),
    .en_wr_i(en_wr), .en_val_i(io_wdata_i), .idx_i(dec_idx),
    .sel_o(sel_o), .act_idx_o(act_idx_o), .act_vld_o(act_vld_o),
    .err_o(recover_err_o)
  );

  csel_mem_route #(
    .NSLOT(NSLOT), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) i_mem (
    .sel_i(sel_o), .act_idx_i(act_idx_o), .act_vld_i(act_vld_o),
    .mem_rd_i(mem_rd_i), .mem_wr_i(mem_wr_i), .mem_addr_i(mem_addr_i),
    .mem_wdata_i(mem_wdata_i), .mem_rdata_i(mem_rdata_i),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_off_o(mem_off_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_o(mem_rdata_o)
  );
endmodule

// File: rtl/card_select_chk.sv
module card_select_chk #(
  parameter int unsigned NSLOT   = 28,
  parameter int unsigned SPAN_LG = 8,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned IDX_W  = $clog2(NSLOT)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               recover_en_i,
  input logic               io_wr_i,
  input logic               io_wdata_i,
  input logic               dec_hit,
  input logic [IDX_W-1:0]   dec_idx,
  input logic [SPAN_LG-1:0] dec_off,
  input logic [NSLOT-1:0]   sel_o,
  input logic [IDX_W-1:0]   act_idx_o,
  input logic               act_vld_o,
  input logic               recover_err_o,
  input logic [NSLOT-1:0]   mem_rd_o,
  input logic [NSLOT-1:0]   mem_wr_o,
  input logic [DATA_W-1:0]  mem_rdata_o
);
  logic en_hit;
  assign en_hit = io_wr_i && dec_hit && (dec_off == '0);

  a_r4_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));

  a_r4_enable_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_hit && io_wdata_i) |=>
      (act_vld_o && (act_idx_o == $past(dec_idx)) &&
       (sel_o == (NSLOT'(1) << $past(dec_idx)))));

  a_r5_other_disable_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_hit && !io_wdata_i && (!act_vld_o || (dec_idx != act_idx_o))) |=>
      ($stable(sel_o) && $stable(act_vld_o)));

  a_r6_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_hit && !io_wdata_i && act_vld_o && (dec_idx == act_idx_o) && !recover_en_i) |=>
      (!act_vld_o && (sel_o == '0)));

  a_r7_err_has_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_err_o |-> (act_vld_o && $past(recover_en_i)));

  a_r8_idle_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_vld_o |-> ((mem_rd_o == '0) && (mem_wr_o == '0) && (mem_rdata_o == '0)));

  a_r9_strobe_in_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((mem_rd_o | mem_wr_o) & ~sel_o) == '0));

  a_r11_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_hit |=> ($stable(sel_o) && !recover_err_o));
endmodule

bind card_select_ctrl card_select_chk #(
  .NSLOT(NSLOT), .SPAN_LG(SPAN_LG), .DATA_W(DATA_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .recover_en_i(recover_en_i),
  .io_wr_i(io_wr_i), .io_wdata_i(io_wdata_i),
  .dec_hit(dec_hit), .dec_idx(dec_idx), .dec_off(dec_off),
  .sel_o(sel_o), .act_idx_o(act_idx_o), .act_vld_o(act_vld_o),
  .recover_err_o(recover_err_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
  .mem_rdata_o(mem_rdata_o)
);

// File: tb/test_card_select_ctrl.sv
module test_card_select_ctrl;
  localparam int NS = 28;

  logic clk = 0, rst_ni = 0;
  logic ext_mode = 0, recover_en = 0;
  logic io_rd = 0, io_wr = 0, io_wdata = 0;
  logic [15:0] io_addr = '0;
  logic io_rdata;
  logic [NS-1:0] io_rd_s, io_wr_s;
  logic [7:0] io_off;
  logic io_wdata_s;
  logic [NS-1:0] io_cards = 28'h96C_35A5;
  logic mem_rd = 0, mem_wr = 0;
  logic [15:0] mem_addr = '0;
  logic [7:0] mem_wdata = 8'h3C, mem_rdata, mem_wdata_s;
  logic [NS-1:0] mem_rd_s, mem_wr_s, sel;
  logic [12:0] mem_off;
  logic [NS*8-1:0] mem_cards;
  logic [4:0] act_idx;
  logic act_vld, err;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  card_select_ctrl i_card_select_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .ext_mode_i(ext_mode), .recover_en_i(recover_en),
    .io_rd_i(io_rd), .io_wr_i(io_wr), .io_addr_i(io_addr), .io_wdata_i(io_wdata),
    .io_rdata_o(io_rdata), .io_rd_o(io_rd_s), .io_wr_o(io_wr_s), .io_off_o(io_off),
    .io_wdata_o(io_wdata_s), .io_rdata_i(io_cards),
    .mem_rd_i(mem_rd), .mem_wr_i(mem_wr), .mem_addr_i(mem_addr), .mem_wdata_i(mem_wdata),
    .mem_rdata_o(mem_rdata), .mem_rd_o(mem_rd_s), .mem_wr_o(mem_wr_s), .mem_off_o(mem_off),
    .mem_wdata_o(mem_wdata_s), .mem_rdata_i(mem_cards),
    .sel_o(sel), .act_idx_o(act_idx), .act_vld_o(act_vld), .recover_err_o(err)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] bit_of(input int k);
    return 64'(1) << k;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    io_wr = 0; io_rd = 0; mem_rd = 0; mem_wr = 0;
  endtask

  task automatic io_write(input logic [15:0] a, input logic d);
    io_addr = a; io_wdata = d; io_wr = 1;
    tick();
  endtask

  task automatic expect_sel(input string tag, input int k);
    chk({tag, " sel"}, 64'(sel), bit_of(k));
    chk({tag, " idx"}, 64'(act_idx), 64'(k));
    chk({tag, " vld"}, 64'(act_vld), 64'd1);
  endtask

  task automatic t_reset();
    chk("R1 sel", 64'(sel), 0);
    chk("R1 vld", 64'(act_vld), 0);
    chk("R1 err", 64'(err), 0);
  endtask

  task automatic t_std_decode();
    ext_mode = 0;
    io_addr = 16'h1305; io_wdata = 1; io_wr = 1; #1;
    chk("R2 strobe slot3", 64'(io_wr_s), bit_of(3));
    chk("R2 offset", 64'(io_off), 64'h05);
    chk("R2 wdata", 64'(io_wdata_s), 64'd1);
    io_addr = 16'h0F00; #1;
    chk("R2 below range", 64'(io_wr_s), 0);
    io_addr = 16'h2000; #1;
    chk("R2 above range", 64'(io_wr_s), 0);
    tick();
    chk("R11 nonzero offset no select", 64'(act_vld), 0);
  endtask

  task automatic t_ext_decode();
    ext_mode = 1;
    io_addr = 16'h0400; io_rd = 1; #1;
    chk("R3 slot0", 64'(io_rd_s), bit_of(0));
    io_addr = 16'h1F10; #1;
    chk("R3 slot27", 64'(io_rd_s), bit_of(27));
    chk("R3 offset", 64'(io_off), 64'h10);
    io_addr = 16'h03FF; #1;
    chk("R3 below base", 64'(io_rd_s), 0);
    tick();
    io_write(16'h1F00, 1);
    expect_sel("R3 enable slot27", 27);
    io_write(16'h1F00, 0);
    chk("R3 disable slot27", 64'(act_vld), 0);
    ext_mode = 0;
  endtask

  task automatic t_enable();
    io_addr = 16'h1100; io_wdata = 1; io_wr = 1; #1;
    chk("R4 not before edge", 64'(sel), 0);
    tick();
    expect_sel("R4 slot1", 1);
    io_write(16'h1500, 1);
    expect_sel("R4 replace slot5", 5);
  endtask

  task automatic t_disable_other();
    io_write(16'h1100, 0);
    expect_sel("R5 other disable", 5);
  endtask

  task automatic t_disable_active();
    recover_en = 0;
    io_write(16'h1500, 0);
    chk("R6 sel", 64'(sel), 0);
    chk("R6 vld", 64'(act_vld), 0);
  endtask

  task automatic t_recover();
    recover_en = 1;
    io_write(16'h1200, 1);
    io_write(16'h1900, 1);
    io_write(16'h1400, 1);
    expect_sel("R7 setup", 4);
    io_write(16'h1400, 0);
    expect_sel("R7 fallback highest", 9);
    chk("R7 err pulse", 64'(err), 64'd1);
    tick();
    chk("R7 err one cycle", 64'(err), 0);
    io_write(16'h1900, 0);
    expect_sel("R7 fallback next", 2);
    chk("R7 err again", 64'(err), 64'd1);
    io_write(16'h1200, 0);
    chk("R7 none left vld", 64'(act_vld), 0);
    chk("R7 none left err", 64'(err), 0);
    recover_en = 0;
  endtask

  task automatic t_mem_idle();
    mem_addr = 16'h4000; mem_rd = 1; #1;
    chk("R8 rdata", 64'(mem_rdata), 0);
    chk("R8 rd strobe", 64'(mem_rd_s), 0);
    mem_rd = 0; mem_wr = 1; #1;
    chk("R8 wr strobe", 64'(mem_wr_s), 0);
    tick();
  endtask

  task automatic t_mem_active();
    io_write(16'h1700, 1);
    mem_addr = 16'h4123; mem_rd = 1; #1;
    chk("R9 rd strobe", 64'(mem_rd_s), bit_of(7));
    chk("R9 rdata", 64'(mem_rdata), 64'h47);
    chk("R9 offset", 64'(mem_off), 64'h123);
    mem_rd = 0; mem_addr = 16'h5FFF; mem_wr = 1; #1;
    chk("R9 wr strobe", 64'(mem_wr_s), bit_of(7));
    chk("R9 wdata", 64'(mem_wdata_s), 64'h3C);
    mem_wr = 0; mem_addr = 16'h6000; mem_rd = 1; #1;
    chk("R9 outside strobe", 64'(mem_rd_s), 0);
    chk("R9 outside rdata", 64'(mem_rdata), 0);
    tick();
  endtask

  task automatic t_io_inactive();
    io_addr = 16'h1C03; io_wdata = 1; io_wr = 1; #1;
    chk("R10 wr to inactive", 64'(io_wr_s), bit_of(12));
    io_wr = 0; io_rd = 1; #1;
    chk("R10 rd to inactive", 64'(io_rd_s), bit_of(12));
    chk("R10 rdata", 64'(io_rdata), 64'(io_cards[12]));
    io_addr = 16'h1A02; #1;
    chk("R10 rdata slot10", 64'(io_rdata), 64'(io_cards[10]));
    tick();
    expect_sel("R10 keeps active", 7);
  endtask

  task automatic t_no_change();
    io_write(16'h1C01, 1);
    expect_sel("R11 offset1", 7);
    io_write(16'h2000, 1);
    expect_sel("R11 out of range", 7);
    io_write(16'h1701, 0);
    expect_sel("R11 offset1 zero", 7);
  endtask

  task automatic t_same_cycle();
    io_addr = 16'h1A00; io_wdata = 1; io_wr = 1;
    mem_addr = 16'h4000; mem_rd = 1; #1;
    chk("R12 old strobe", 64'(mem_rd_s), bit_of(7));
    chk("R12 old rdata", 64'(mem_rdata), 64'h47);
    tick();
    expect_sel("R12 new", 10);
    mem_addr = 16'h4000; mem_rd = 1; #1;
    chk("R12 new rdata", 64'(mem_rdata), 64'h4A);
    tick();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    for (int k = 0; k < NS; k++) mem_cards[k*8 +: 8] = 8'(8'h40 + k);
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_std_decode();
    t_ext_decode();
    t_enable();
    t_disable_other();
    t_disable_active();
    t_recover();
    t_mem_idle();
    t_mem_active();
    t_io_inactive();
    t_no_change();
    t_same_cycle();
    finish_run();
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end
endmodule